// File: doc/BRIEF.md
# Reset Stretch and Initialization Sequencer

This block takes the chip's asynchronous, active-low external reset pin and turns it into an internal reset that lasts longer than the pin. Once that longer reset ends, the block opens a register-initialization window. The window closes when a separate initializer reports completion, or when a timeout expires if no report arrives. The block then enters normal operation. The current phase is reported on a two-bit output, so that the neighbouring logic and a testbench can follow the sequence.

While the sequence is running, the block gates the serial control port. A transfer addressed to this device is refused until normal operation begins. A transfer addressed to any other device on the same bus is passed through at all times, even while the pin is held low. For as long as internal reset is active, the block also tells the horizontal-drive generator to run from the standby clock.

Two cascaded clock-enable dividers run from the reference clock: a fast one and a slow one. Neither is part of the reset domain, so their tick cadence is the same before, during and after any number of reset pulses. All durations are given in nanoseconds and are converted to reference-clock cycles from the clock-frequency parameter. At the default of 20.25 MHz this gives 81 stretch cycles and 1215 timeout cycles.

Top module: `rst_stretch_seq`

## Requirements
- R1: While `rst_pin_n` is low, `seq_phase` reads 0 (RESET), `int_rst_n` is 0 and `stby_clk_force` is 1. This holds immediately, with no clock edge needed.
- R2: The pin is released between two clock edges. `seq_phase` stays 0 through the first two rising edges after the release (two-flop synchronizer). It becomes 1 (STRETCH) at the third edge and stays 1 for exactly STRETCH_CYC cycles, where STRETCH_CYC = CLK_HZ/1000 * STRETCH_NS / 1e6.
- R3: When STRETCH ends, `seq_phase` becomes 2 (INIT). From that edge on, `int_rst_n` is 1 and `stby_clk_force` is 0. If `init_done` stays low, INIT lasts exactly INIT_CYC cycles (same formula, using INIT_NS) and is followed by 3 (RUN).
- R4: `init_done` is sampled only in INIT. If it is high at the k-th rising edge of INIT (k counted from 1), the phase is 3 after that edge, so INIT lasts min(k, INIT_CYC) cycles. If `init_done` is already high during RESET or STRETCH, it does not shorten STRETCH, and INIT then lasts 1 cycle.
- R5: Once in RUN (3), the phase holds at 3, with `int_rst_n` = 1 and `stby_clk_force` = 0, until the pin is next asserted. Phases only ever advance in the order 0, 1, 2, 3.
- R6: `grant_self` = `xfer_req` & `xfer_is_self` in RUN only. In phases 0 to 2, a request for this device gives `refuse_self` = 1 and `grant_self` = 0.
- R7: `grant_other` = `xfer_req` & !`xfer_is_self` in every phase, including while the pin is low.
- R8: `tick_fast` is high for one cycle in every DIV_FAST cycles. `tick_slow` is high for one cycle in every DIV_FAST*DIV_SLOW cycles. Pin activity never changes either period.
- R9: Asserting the pin during STRETCH or INIT returns the phase to 0 at once. The next release restarts the full sequence of R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| init_done | input | 1 | Completion flag from the register initializer |
| xfer_req | input | 1 | A serial-bus transfer is being addressed |
| xfer_is_self | input | 1 | The addressed device is this one |
| int_rst_n | output | 1 | Internal reset, active low, stretched |
| stby_clk_force | output | 1 | Forces the horizontal-drive generator onto the standby clock |
| seq_phase | output | 2 | 0 RESET, 1 STRETCH, 2 INIT, 3 RUN |
| grant_self | output | 1 | Transfer to this device accepted |
| refuse_self | output | 1 | Transfer to this device refused |
| grant_other | output | 1 | Transfer to another device passed through |
| tick_fast | output | 1 | Fast divider enable tick |
| tick_slow | output | 1 | Slow divider enable tick |

## Verification
The assertions assume the following about the inputs:
- `rst_pin_n` changes only away from the reference-clock edge.
- `init_done` is a level that is stable at each sampling edge.
- `xfer_req` and `xfer_is_self` are steady before outputs are read.

The stimulus drives all inputs at the falling edge and samples the outputs 1 ns later. Pin releases therefore always fall midway between rising edges, which is where the two-edge synchronizer latency in R2 is defined. The sweep raises `init_done` at every INIT cycle up to and beyond the timeout, so the arithmetic expectation min(k, INIT_CYC) is exercised at both ends.

// File: rtl/rsis_pkg.sv
// Shared types for the reset stretch and initialization sequencer.
// Assumes nothing beyond a 2-bit phase code that neighbours decode.
package rsis_pkg;
    // Phase code; bit 1 set means internal reset is released.
    typedef enum logic [1:0] {
        PH_RESET   = 2'd0,
        PH_STRETCH = 2'd1,
        PH_INIT    = 2'd2,
        PH_RUN     = 2'd3
    } phase_e;
endpackage

// File: rtl/rsis_pin_sync.sv
// Reset pin synchronizer: asserts asynchronously, releases after STAGES
// rising edges of clk. Assumes pin_n is glitch-filtered off chip.
module rsis_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic sync_n
);
    logic [STAGES-1:0] shreg;

    // Shift ones in after release; clear all stages the moment the pin drops.
    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-2:0], 1'b1};
        end
    end

    assign sync_n = shreg[STAGES-1];
endmodule

// File: rtl/rsis_phase_fsm.sv
// Phase sequencer: RESET -> STRETCH (fixed length) -> INIT (ends on done
// or timeout) -> RUN. Synchronous active-low reset from the synchronizer.
// Assumes init_done is synchronous to clk.
module rsis_phase_fsm
    import rsis_pkg::*;
#(
    parameter int STRETCH_CYC = 81,
    parameter int INIT_CYC    = 1215
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   init_done,
    output phase_e state
);
    localparam int MAXC = (STRETCH_CYC > INIT_CYC) ? STRETCH_CYC : INIT_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] S_LAST = CW'(STRETCH_CYC - 1);
    localparam logic [CW-1:0] I_LAST = CW'(INIT_CYC - 1);

    phase_e        state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    // Next-state and phase-counter decision.
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt + 1'b1;
        unique case (state)
            PH_RESET: begin
                state_nx = PH_STRETCH;
                cnt_nx   = '0;
            end
            PH_STRETCH: begin
                if (cnt == S_LAST) begin
                    state_nx = PH_INIT;
                    cnt_nx   = '0;
                end
            end
            PH_INIT: begin
                if (init_done || cnt == I_LAST) begin
                    state_nx = PH_RUN;
                    cnt_nx   = '0;
                end
            end
            default: begin
                cnt_nx = '0;
            end
        endcase
    end

    // State and counter registers, cleared by the synchronized reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_RESET;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    AST_STRETCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_STRETCH) |-> (cnt <= S_LAST)); // R2
    AST_INIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_INIT) |-> (cnt <= I_LAST)); // R3
    AST_INIT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_INIT) |-> ($past(state) == PH_STRETCH || $past(state) == PH_INIT)); // R3
    AST_DONE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_INIT && init_done) |=> (state == PH_RUN)); // R4
    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_RUN) |=> (state == PH_RUN)); // R5
endmodule

// File: rtl/rsis_free_div.sv
// Always-on clock-enable divider: one tick per DIV enabled cycles.
// Deliberately has no reset; starts from a power-up value of zero.
module rsis_free_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic en,
    output logic tick
);
    localparam int W = $clog2(DIV + 1);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt = '0;

    // Wrap-around count of enabled cycles.
    always_ff @(posedge clk) begin
        if (en) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == LAST);

    if (DIV > 1) begin : g_spacing
        AST_TICK_SPACING: assert property (@(posedge clk)
            tick |=> !tick); // R8
    end
endmodule

// File: rtl/rst_stretch_seq.sv
// Top: reset stretch, init window, serial-access gate and always-on
// dividers. Assumes rst_pin_n may change at any time; other inputs are
// synchronous to clk_ref.
module rst_stretch_seq
    import rsis_pkg::*;
#(
    parameter int CLK_HZ      = 20_250_000,
    parameter int STRETCH_NS  = 4000,
    parameter int INIT_NS     = 60000,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_FAST    = 4,
    parameter int DIV_SLOW    = 5
) (
    input  logic       clk_ref,
    input  logic       rst_pin_n,
    input  logic       init_done,
    input  logic       xfer_req,
    input  logic       xfer_is_self,
    output logic       int_rst_n,
    output logic       stby_clk_force,
    output logic [1:0] seq_phase,
    output logic       grant_self,
    output logic       refuse_self,
    output logic       grant_other,
    output logic       tick_fast,
    output logic       tick_slow
);
    localparam longint KHZ         = longint'(CLK_HZ) / 1000;
    localparam int     STRETCH_CYC = int'(KHZ * STRETCH_NS / 1_000_000);
    localparam int     INIT_CYC    = int'(KHZ * INIT_NS / 1_000_000);

    logic   rst_sync_n;
    phase_e fsm_state;
    phase_e phase_now;
    logic   in_run;

    rsis_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk_ref),
        .pin_n  (rst_pin_n),
        .sync_n (rst_sync_n)
    );

    rsis_phase_fsm #(.STRETCH_CYC(STRETCH_CYC), .INIT_CYC(INIT_CYC)) fsm_i (
        .clk       (clk_ref),
        .rst_n     (rst_sync_n),
        .init_done (init_done),
        .state     (fsm_state)
    );

    // Force RESET on the outputs the moment the pin drops.
    assign phase_now      = rst_sync_n ? fsm_state : PH_RESET;
    assign seq_phase      = phase_now;
    assign int_rst_n      = phase_now[1];
    assign stby_clk_force = !phase_now[1];
    assign in_run         = (phase_now == PH_RUN);

    // Serial-port gate: own-address traffic waits for RUN, other traffic passes.
    assign grant_self  = xfer_req && xfer_is_self && in_run;
    assign refuse_self = xfer_req && xfer_is_self && !in_run;
    assign grant_other = xfer_req && !xfer_is_self;

    logic fast_en;
    assign fast_en = 1'b1;

    rsis_free_div #(.DIV(DIV_FAST)) div_fast_i (
        .clk  (clk_ref),
        .en   (fast_en),
        .tick (tick_fast)
    );

    rsis_free_div #(.DIV(DIV_SLOW)) div_slow_i (
        .clk  (clk_ref),
        .en   (tick_fast),
        .tick (tick_slow)
    );

    AST_GRANT_IN_RUN: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
        grant_self |-> (fsm_state == PH_RUN)); // R6
    AST_FORCE_IN_RESET: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
        (fsm_state == PH_STRETCH) |-> (stby_clk_force && !int_rst_n)); // R2
endmodule

// File: tb/rst_stretch_seq_tb_top.sv
// Sweep bench: every init_done arrival point, reset aborts, gate and dividers.
module rst_stretch_seq_tb_top;
    localparam int CLK_HZ = 2_000_000;
    localparam int S_CYC  = 8;     // 2000 * 4000 / 1e6
    localparam int I_CYC  = 120;   // 2000 * 60000 / 1e6
    localparam int DF     = 4;
    localparam int DS     = 5;

    logic clk = 1'b0;
    logic rst_pin_n, init_done, xfer_req, xfer_is_self;
    logic int_rst_n, stby_clk_force, grant_self, refuse_self, grant_other;
    logic tick_fast, tick_slow;
    logic [1:0] seq_phase;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    rst_stretch_seq #(.CLK_HZ(CLK_HZ), .DIV_FAST(DF), .DIV_SLOW(DS)) dut_i (
        .clk_ref(clk), .rst_pin_n(rst_pin_n), .init_done(init_done),
        .xfer_req(xfer_req), .xfer_is_self(xfer_is_self),
        .int_rst_n(int_rst_n), .stby_clk_force(stby_clk_force),
        .seq_phase(seq_phase), .grant_self(grant_self),
        .refuse_self(refuse_self), .grant_other(grant_other),
        .tick_fast(tick_fast), .tick_slow(tick_slow));

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Checks made while the pin is low (R1, R7).
    task automatic check_held(input string tag);
        xfer_req = 1'b1; xfer_is_self = 1'b0;
        #1;
        check(seq_phase == 2'd0, "R1", {tag, " phase"}, seq_phase, 0);
        check(int_rst_n == 1'b0, "R1", {tag, " int_rst_n"}, int_rst_n, 0);
        check(stby_clk_force == 1'b1, "R1", {tag, " stby"}, stby_clk_force, 1);
        check(grant_other == 1'b1, "R7", {tag, " other"}, grant_other, 1);
        xfer_is_self = 1'b1;
        #1;
        check(refuse_self && !grant_self, "R6", {tag, " refuse"}, refuse_self, 1);
    endtask

    // Assert the pin at a falling edge, hold, and leave it low at a falling edge.
    task automatic pulse_reset();
        @(negedge clk);
        rst_pin_n = 1'b0;
        check_held("pulse");
        repeat (3) @(negedge clk);
    endtask

    // Release the pin now and tally phases; done_at: 0 preset, -1 never, k>0 k-th INIT sample.
    task automatic release_and_measure(input int done_at);
        int cnt[4];
        int prev, ic, exp_init;
        string tag;
        cnt = '{0, 0, 0, 0};
        prev = 0; ic = 0;
        tag = $sformatf("done_at=%0d", done_at);
        init_done = (done_at == 0);
        rst_pin_n = 1'b1;
        for (int k = 0; k < S_CYC + I_CYC + 20; k++) begin
            @(negedge clk);
            xfer_req = (k % 3) != 0;
            xfer_is_self = k[1];
            #1;
            cnt[seq_phase]++;
            check(seq_phase >= prev, "R5", {tag, " order"}, seq_phase, prev);
            prev = seq_phase;
            check(int_rst_n == seq_phase[1], "R3", {tag, " int_rst_n"}, int_rst_n, seq_phase[1]);
            check(stby_clk_force == !seq_phase[1], "R3", {tag, " stby"}, stby_clk_force, !seq_phase[1]);
            check(grant_self == (xfer_req && xfer_is_self && seq_phase == 2'd3), "R6",
                  {tag, " grant_self"}, grant_self, xfer_req && xfer_is_self && seq_phase == 2'd3);
            check(refuse_self == (xfer_req && xfer_is_self && seq_phase != 2'd3), "R6",
                  {tag, " refuse_self"}, refuse_self, xfer_req && xfer_is_self && seq_phase != 2'd3);
            check(grant_other == (xfer_req && !xfer_is_self), "R7",
                  {tag, " grant_other"}, grant_other, xfer_req && !xfer_is_self);
            if (seq_phase == 2'd2) begin
                ic++;
                if (done_at > 0 && ic == done_at) init_done = 1'b1;
            end
            if (cnt[3] == 4) break;
        end
        exp_init = (done_at == 0) ? 1 : (done_at < 0 ? I_CYC :
                   (done_at < I_CYC ? done_at : I_CYC));
        check(cnt[0] == 2, "R2", {tag, " sync cycles"}, cnt[0], 2);
        check(cnt[1] == S_CYC, "R2", {tag, " stretch length"}, cnt[1], S_CYC);
        check(cnt[2] == exp_init, "R4", {tag, " init length"}, cnt[2], exp_init);
        check(cnt[3] == 4, "R5", {tag, " run held"}, cnt[3], 4);
        init_done = 1'b0;
    endtask

    // Pull the pin again after `at` samples of phase `ph` (R9).
    task automatic abort_in(input int ph, input int at);
        int seen;
        seen = 0;
        pulse_reset();
        rst_pin_n = 1'b1;
        for (int k = 0; k < S_CYC + I_CYC + 20; k++) begin
            @(negedge clk);
            #1;
            if (seq_phase == ph[1:0]) seen++;
            if (seen == at) break;
        end
        @(negedge clk);
        rst_pin_n = 1'b0;
        check_held($sformatf("R9 abort ph%0d", ph));
        repeat (2) @(negedge clk);
        release_and_measure(-1);
    endtask

    // Divider cadence monitor across all reset activity (R8).
    int cyc = 0;
    int last_f = -1;
    int last_s = -1;
    always @(negedge clk) begin
        cyc++;
        if (tick_fast) begin
            if (last_f >= 0) check(cyc - last_f == DF, "R8", "fast period", cyc - last_f, DF);
            last_f = cyc;
        end
        if (tick_slow) begin
            if (last_s >= 0) check(cyc - last_s == DF * DS, "R8", "slow period", cyc - last_s, DF * DS);
            last_s = cyc;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got %0d expected %0d", 150000, 0);
        report();
    end

    initial begin
        rst_pin_n = 1'b1; init_done = 1'b0; xfer_req = 1'b0; xfer_is_self = 1'b0;
        #2 rst_pin_n = 1'b0;
        check_held("power-up");
        repeat (3) @(negedge clk);
        release_and_measure(-1);
        for (int j = 0; j <= I_CYC + 2; j++) begin
            pulse_reset();
            release_and_measure(j);
        end
        for (int a = 1; a <= S_CYC; a += 3) abort_in(1, a);
        for (int a = 1; a <= I_CYC; a += 17) abort_in(2, a);
        check(last_s > 0, "R8", "slow ticks seen", last_s > 0, 1);
        report();
    end
endmodule